// File: doc/BRIEF.md
# Linked Frame Descriptor Fetcher

This block reloads the per-channel frame descriptors of a seven-channel display DMA. When a frame-start strobe arrives, it first clears every channel's source address. It then visits the channels in ascending order. For each channel marked active, it reads a four-word descriptor from memory and stores the four words in that channel's registers: link to the next descriptor, frame source address, frame identifier and transfer command. The command word is kept as read. It holds the transfer length in bits 20:2, an end-of-frame interrupt request at bit 21, a start-of-frame interrupt request at bit 22 and a palette-load flag at bit 26.

The descriptor pointer for a channel normally comes from its stored link register. Software can arm a one-shot branch register instead. An armed branch redirects one fetch, can raise a branch event towards the interrupt logic, and then disarms itself. A channel is skipped when its 16-byte descriptor does not fit entirely inside a configured memory window. A memory error response abandons that channel's fetch and reports a bus-error event that carries the channel number. Software writes the link and branch registers through a small write port and reads every per-channel register through a combinational read port.

Top module: `fdesc_fetch`

## Requirements
- R1: After reset, every per-channel register reads zero, `busy_o`, `mem_req_o` and all event strobes are low.
- R2: A software write with `cfg_branch_i`=0 stores `cfg_wdata_i & 0xFFFFFFF0` in the channel's link register. A write with `cfg_branch_i`=1 stores `cfg_wdata_i & 0xFFFFFFF3` in its branch register. The read select codes are: 0 link, 1 source, 2 frame ID, 3 command, 4 branch.
- R3: A frame-start strobe accepted while idle sets the source register of every channel to zero, including inactive channels.
- R4: A channel whose `chan_active_i` bit is low makes no memory request, and its link, ID, command and branch registers keep their values.
- R5: When branch bit 0 (armed) is set, the fetch address is the branch value with bits 3:0 cleared, and bit 0 is then cleared while the other bits are kept. If branch bit 1 is also set, `branch_irq_o` pulses once with `branch_ch_o` equal to the channel.
- R6: When the branch is not armed, the fetch address is the link register with bits 3:0 cleared. On success, the link, source, ID and command registers take memory words 0, 1, 2 and 3.
- R7: A descriptor is fetched only if `win_lo_i <= addr` and `addr + 16 <= win_hi_i`. Otherwise no request is made and the source stays zero. An armed branch is still consumed.
- R8: Channels are fetched in ascending order. Each fetch reads the addresses base, base+4, base+8 and base+12 in that order, and `mem_addr_o` is word aligned and held while a request waits.
- R9: A response with `mem_rerr_i` high ends that channel's fetch without updating its registers, pulses `berr_o` with `berr_ch_o` equal to the channel, and servicing continues with the next channel.
- R10: `done_o` pulses once, with `busy_o` low, after the last channel has been handled. A frame-start strobe is ignored while busy, and no request is made while idle.
- R11: A software write to a branch register takes priority over the self-clear of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Starts a descriptor reload |
| chan_active_i | input | NCH | Per-channel active flags |
| win_lo_i | input | 32 | Lowest valid descriptor byte address |
| win_hi_i | input | 32 | Exclusive upper bound of the window |
| cfg_we_i | input | 1 | Software write strobe |
| cfg_branch_i | input | 1 | 1: write branch register, 0: write link register |
| cfg_ch_i | input | CHW | Channel for the write |
| cfg_wdata_i | input | 32 | Write data |
| rd_ch_i | input | CHW | Channel for readback |
| rd_sel_i | input | 3 | Register select for readback |
| rd_data_o | output | 32 | Readback data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory word address |
| mem_rvalid_i | input | 1 | Response for the pending request |
| mem_rdata_i | input | 32 | Response data |
| mem_rerr_i | input | 1 | Response is an error |
| busy_o | output | 1 | Reload in progress |
| done_o | output | 1 | Reload finished, one-cycle pulse |
| branch_irq_o | output | 1 | Branch event pulse |
| branch_ch_o | output | CHW | Channel of the branch event |
| berr_o | output | 1 | Bus-error event pulse |
| berr_ch_o | output | CHW | Channel of the bus error |

## Verification
The sequencer clears a branch register's armed bit in the cycle it picks that branch as the fetch pointer, and software may write the same register in that same cycle. The bench raises the frame strobe and drives the branch write in the next cycle, so the write lands exactly on the selection edge for channel 0. It then checks three things: the register holds the newly written value, the fetch used the old branch address, and no branch event fires, because the old value had no interrupt bit set.

// File: rtl/fdesc_pkg.sv
package fdesc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEL, ST_FETCH} fd_state_e;
  localparam logic [2:0] RD_LINK = 3'd0;
  localparam logic [2:0] RD_SRC  = 3'd1;
  localparam logic [2:0] RD_ID   = 3'd2;
  localparam logic [2:0] RD_CMD  = 3'd3;
  localparam logic [2:0] RD_BR   = 3'd4;
  localparam logic [31:0] LINK_MASK = 32'hFFFF_FFF0;
  localparam logic [31:0] BR_MASK   = 32'hFFFF_FFF3;
endpackage

// File: rtl/fdesc_win.sv
module fdesc_win (
  input  logic [31:0] addr_i,
  input  logic [31:0] lo_i,
  input  logic [31:0] hi_i,
  output logic        ok_o
);
  logic [32:0] end_w;
  assign end_w = {1'b0, addr_i} + 33'd16;
  assign ok_o  = (addr_i >= lo_i) && (end_w <= {1'b0, hi_i});
endmodule

// File: rtl/fdesc_regs.sv
module fdesc_regs
  import fdesc_pkg::*;
#(
  parameter int NCH = 7,
  parameter int CHW = $clog2(NCH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sw_we_i,
  input  logic                  sw_branch_i,
  input  logic [CHW-1:0]        sw_ch_i,
  input  logic [31:0]           sw_wdata_i,
  input  logic                  clr_src_i,
  input  logic                  br_clr_i,
  input  logic                  commit_i,
  input  logic [CHW-1:0]        act_ch_i,
  input  logic [31:0]           c_link_i,
  input  logic [31:0]           c_src_i,
  input  logic [31:0]           c_id_i,
  input  logic [31:0]           c_cmd_i,
  input  logic [CHW-1:0]        rd_ch_i,
  input  logic [2:0]            rd_sel_i,
  output logic [31:0]           rd_data_o,
  output logic [NCH-1:0][31:0]  link_o,
  output logic [NCH-1:0][31:0]  branch_o
);
  logic [NCH-1:0][31:0] src_q, id_q, cmd_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sw_hit, act_hit;
    assign sw_hit  = sw_we_i && (sw_ch_i == CHW'(g));
    assign act_hit = act_ch_i == CHW'(g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        link_o[g]   <= '0;
        src_q[g]    <= '0;
        id_q[g]     <= '0;
        cmd_q[g]    <= '0;
        branch_o[g] <= '0;
      end else begin
        // fetched descriptor wins over a software link write
        if (commit_i && act_hit) begin
          link_o[g] <= c_link_i;
          src_q[g]  <= c_src_i;
          id_q[g]   <= c_id_i;
          cmd_q[g]  <= c_cmd_i;
        end else begin
          if (sw_hit && !sw_branch_i) link_o[g] <= sw_wdata_i & LINK_MASK;
          if (clr_src_i) src_q[g] <= '0;
        end
        // software write wins over self-clear
        if (sw_hit && sw_branch_i) branch_o[g] <= sw_wdata_i & BR_MASK;
        else if (br_clr_i && act_hit) branch_o[g][0] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_ch_i == CHW'(i)) begin
        unique case (rd_sel_i)
          RD_LINK: rd_data_o = link_o[i];
          RD_SRC:  rd_data_o = src_q[i];
          RD_ID:   rd_data_o = id_q[i];
          RD_CMD:  rd_data_o = cmd_q[i];
          RD_BR:   rd_data_o = branch_o[i];
          default: rd_data_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/fdesc_seq.sv
module fdesc_seq
  import fdesc_pkg::*;
#(
  parameter int NCH = 7,
  parameter int CHW = $clog2(NCH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [NCH-1:0]        active_i,
  input  logic [NCH-1:0][31:0]  link_i,
  input  logic [NCH-1:0][31:0]  branch_i,
  output logic [31:0]           ptr_o,
  input  logic                  ptr_ok_i,
  output logic                  mem_req_o,
  output logic [31:0]           mem_addr_o,
  input  logic                  mem_rvalid_i,
  input  logic [31:0]           mem_rdata_i,
  input  logic                  mem_rerr_i,
  output logic                  clr_src_o,
  output logic                  br_clr_o,
  output logic                  commit_o,
  output logic [CHW-1:0]        ch_o,
  output logic [31:0]           c_link_o,
  output logic [31:0]           c_src_o,
  output logic [31:0]           c_id_o,
  output logic [31:0]           c_cmd_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  branch_irq_o,
  output logic [CHW-1:0]        branch_ch_o,
  output logic                  berr_o,
  output logic [CHW-1:0]        berr_ch_o
);
  fd_state_e      state_q;
  logic [CHW-1:0] ch_q;
  logic [1:0]     word_q;
  logic [31:0]    base_q;
  logic [31:0]    buf_q [3];
  logic           cur_act;
  logic [31:0]    cur_link, cur_br;
  logic           sel_live, armed;

  always_comb begin
    cur_act  = 1'b0;
    cur_link = '0;
    cur_br   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_q == CHW'(i)) begin
        cur_act  = active_i[i];
        cur_link = link_i[i];
        cur_br   = branch_i[i];
      end
    end
  end

  assign sel_live   = (state_q == ST_SEL) && (ch_q < CHW'(NCH)) && cur_act;
  assign armed      = cur_br[0];
  assign ptr_o      = armed ? {cur_br[31:4], 4'h0} : {cur_link[31:4], 4'h0};
  assign br_clr_o   = sel_live && armed;
  assign clr_src_o  = (state_q == ST_IDLE) && start_i;
  assign mem_req_o  = state_q == ST_FETCH;
  assign mem_addr_o = base_q + {28'h0, word_q, 2'b00};
  assign commit_o   = mem_req_o && mem_rvalid_i && !mem_rerr_i && (word_q == 2'd3);
  assign ch_o       = ch_q;
  assign c_link_o   = buf_q[0];
  assign c_src_o    = buf_q[1];
  assign c_id_o     = buf_q[2];
  assign c_cmd_o    = mem_rdata_i;
  assign busy_o     = state_q != ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      ch_q         <= '0;
      word_q       <= '0;
      base_q       <= '0;
      for (int i = 0; i < 3; i++) buf_q[i] <= '0;
      done_o       <= 1'b0;
      branch_irq_o <= 1'b0;
      branch_ch_o  <= '0;
      berr_o       <= 1'b0;
      berr_ch_o    <= '0;
    end else begin
      done_o       <= 1'b0;
      branch_irq_o <= 1'b0;
      berr_o       <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SEL;
          ch_q    <= '0;
        end
        ST_SEL: begin
          if (ch_q >= CHW'(NCH)) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (cur_act) begin
            if (armed && cur_br[1]) begin
              branch_irq_o <= 1'b1;
              branch_ch_o  <= ch_q;
            end
            if (ptr_ok_i) begin
              base_q  <= ptr_o;
              word_q  <= '0;
              state_q <= ST_FETCH;
            end else begin
              ch_q <= ch_q + CHW'(1);
            end
          end else begin
            ch_q <= ch_q + CHW'(1);
          end
        end
        ST_FETCH: if (mem_rvalid_i) begin
          if (mem_rerr_i) begin
            berr_o    <= 1'b1;
            berr_ch_o <= ch_q;
            ch_q      <= ch_q + CHW'(1);
            state_q   <= ST_SEL;
          end else if (word_q == 2'd3) begin
            ch_q    <= ch_q + CHW'(1);
            state_q <= ST_SEL;
          end else begin
            buf_q[word_q] <= mem_rdata_i;
            word_q        <= word_q + 2'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fdesc_fetch.sv
module fdesc_fetch
  import fdesc_pkg::*;
#(
  parameter int NCH = 7,
  localparam int CHW = $clog2(NCH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_start_i,
  input  logic [NCH-1:0]  chan_active_i,
  input  logic [31:0]     win_lo_i,
  input  logic [31:0]     win_hi_i,
  input  logic            cfg_we_i,
  input  logic            cfg_branch_i,
  input  logic [CHW-1:0]  cfg_ch_i,
  input  logic [31:0]     cfg_wdata_i,
  input  logic [CHW-1:0]  rd_ch_i,
  input  logic [2:0]      rd_sel_i,
  output logic [31:0]     rd_data_o,
  output logic            mem_req_o,
  output logic [31:0]     mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [31:0]     mem_rdata_i,
  input  logic            mem_rerr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            branch_irq_o,
  output logic [CHW-1:0]  branch_ch_o,
  output logic            berr_o,
  output logic [CHW-1:0]  berr_ch_o
);
  logic [NCH-1:0][31:0] link_w, branch_w;
  logic [31:0] ptr_w, c_link_w, c_src_w, c_id_w, c_cmd_w;
  logic ptr_ok_w, clr_src_w, br_clr_w, commit_w;
  logic [CHW-1:0] ch_w;

  fdesc_win u_win (
    .addr_i (ptr_w),
    .lo_i   (win_lo_i),
    .hi_i   (win_hi_i),
    .ok_o   (ptr_ok_w)
  );

  fdesc_seq #(.NCH(NCH), .CHW(CHW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (frame_start_i),
    .active_i     (chan_active_i),
    .link_i       (link_w),
    .branch_i     (branch_w),
    .ptr_o        (ptr_w),
    .ptr_ok_i     (ptr_ok_w),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_rerr_i   (mem_rerr_i),
    .clr_src_o    (clr_src_w),
    .br_clr_o     (br_clr_w),
    .commit_o     (commit_w),
    .ch_o         (ch_w),
    .c_link_o     (c_link_w),
    .c_src_o      (c_src_w),
    .c_id_o       (c_id_w),
    .c_cmd_o      (c_cmd_w),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .branch_irq_o (branch_irq_o),
    .branch_ch_o  (branch_ch_o),
    .berr_o       (berr_o),
    .berr_ch_o    (berr_ch_o)
  );

  fdesc_regs #(.NCH(NCH), .CHW(CHW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_we_i     (cfg_we_i),
    .sw_branch_i (cfg_branch_i),
    .sw_ch_i     (cfg_ch_i),
    .sw_wdata_i  (cfg_wdata_i),
    .clr_src_i   (clr_src_w),
    .br_clr_i    (br_clr_w),
    .commit_i    (commit_w),
    .act_ch_i    (ch_w),
    .c_link_i    (c_link_w),
    .c_src_i     (c_src_w),
    .c_id_i      (c_id_w),
    .c_cmd_i     (c_cmd_w),
    .rd_ch_i     (rd_ch_i),
    .rd_sel_i    (rd_sel_i),
    .rd_data_o   (rd_data_o),
    .link_o      (link_w),
    .branch_o    (branch_w)
  );
endmodule

// File: rtl/fdesc_fetch_chk.sv
module fdesc_fetch_chk #(
  parameter int NCH = 7,
  localparam int CHW = $clog2(NCH + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           mem_req_o,
  input logic [31:0]    mem_addr_o,
  input logic           mem_rvalid_i,
  input logic           mem_rerr_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           branch_irq_o,
  input logic [CHW-1:0] branch_ch_o,
  input logic           berr_o,
  input logic [CHW-1:0] berr_ch_o
);
  p_addr_aligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  p_addr_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_idle_no_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_err_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i && mem_rerr_i) |=> berr_o);

  p_berr_ch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> berr_ch_o < CHW'(NCH));

  p_branch_ch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_irq_o |-> branch_ch_o < CHW'(NCH));
endmodule

bind fdesc_fetch fdesc_fetch_chk #(.NCH(NCH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_rerr_i   (mem_rerr_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .branch_irq_o (branch_irq_o),
  .branch_ch_o  (branch_ch_o),
  .berr_o       (berr_o),
  .berr_ch_o    (berr_ch_o)
);

// File: tb/tb_fdesc_fetch.sv
module tb_fdesc_fetch;
  localparam int CLK_T = 10;
  localparam int NCH = 7;
  localparam int CHW = 3;

  logic clk = 0, rst_n = 0;
  logic frame_start = 0;
  logic [NCH-1:0] active = '0;
  logic [31:0] win_lo = 32'h1000_0000, win_hi = 32'h1000_1000;
  logic cfg_we = 0, cfg_br = 0;
  logic [CHW-1:0] cfg_ch = '0, rd_ch = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0] rd_sel = '0;
  logic [31:0] rd_data, mem_addr, mem_rdata;
  logic mem_req, mem_rvalid, mem_rerr;
  logic busy, done, br_irq, berr;
  logic [CHW-1:0] br_ch, berr_ch;

  int checks = 0, errors = 0;
  int log_n = 0, done_n = 0, irq_n = 0, berr_n = 0;
  logic [31:0] log_a [64];
  logic [CHW-1:0] irq_ch, berr_chs;

  always #(CLK_T/2) clk = ~clk;

  function automatic logic [31:0] mw(logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign mem_rvalid = mem_req;
  assign mem_rdata  = mw(mem_addr);
  assign mem_rerr   = mem_addr[11:8] == 4'hE;

  fdesc_fetch #(.NCH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .chan_active_i(active),
    .win_lo_i(win_lo), .win_hi_i(win_hi), .cfg_we_i(cfg_we), .cfg_branch_i(cfg_br),
    .cfg_ch_i(cfg_ch), .cfg_wdata_i(cfg_wdata), .rd_ch_i(rd_ch), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_rerr_i(mem_rerr),
    .busy_o(busy), .done_o(done), .branch_irq_o(br_irq), .branch_ch_o(br_ch),
    .berr_o(berr), .berr_ch_o(berr_ch)
  );

  always @(posedge clk) begin
    if (mem_req && mem_rvalid && log_n < 64) begin log_a[log_n] = mem_addr; log_n++; end
    if (done) done_n++;
    if (br_irq) begin irq_n++; irq_ch = br_ch; end
    if (berr) begin berr_n++; berr_chs = berr_ch; end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(string tag, int ch, logic [2:0] sel, logic [31:0] exp);
    rd_ch = CHW'(ch); rd_sel = sel; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(int ch, logic isbr, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_br = isbr; cfg_ch = CHW'(ch); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clr_logs();
    log_n = 0; done_n = 0; irq_n = 0; berr_n = 0;
  endtask

  task automatic reload();
    clr_logs();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    repeat (60) @(negedge clk);
  endtask

  typedef struct packed { logic [2:0] ch; logic isbr; logic [31:0] wd; logic [31:0] exp; } vec_t;
  localparam vec_t VECS [6] = '{
    '{3'd0, 1'b0, 32'h1000_0107, 32'h1000_0100},
    '{3'd6, 1'b0, 32'hABCD_EF0F, 32'hABCD_EF00},
    '{3'd3, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF3},
    '{3'd1, 1'b1, 32'h1000_020C, 32'h1000_0200},
    '{3'd5, 1'b0, 32'h0000_0008, 32'h0000_0000},
    '{3'd4, 1'b1, 32'h8000_0006, 32'h8000_0002}
  };

  initial begin
    repeat (1000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 req", {31'b0, mem_req}, 0);
    chk("R1 events", {29'b0, done, br_irq, berr}, 0);
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < 5; s++) rdchk("R1 regs", c, 3'(s), 0);

    // R2 write masks via table
    foreach (VECS[i]) begin
      wr(VECS[i].ch, VECS[i].isbr, VECS[i].wd);
      rdchk("R2 mask", VECS[i].ch, VECS[i].isbr ? 3'd4 : 3'd0, VECS[i].exp);
    end

    // main reload: ch0 linked, ch2 branch+int, ch3 branch no int, ch5 out of window
    wr(0, 0, 32'h1000_0100); wr(1, 0, 32'h1000_0500); wr(1, 1, 0);
    wr(2, 1, 32'h1000_0203); wr(3, 1, 32'h1000_0301);
    wr(4, 1, 0); wr(5, 0, 32'h2000_0000);
    active = 7'b0101101;
    reload();
    chk("R8 req count", log_n, 12);
    for (int k = 0; k < 4; k++) begin
      chk("R8 ch0 order", log_a[k], 32'h1000_0100 + 4*k);
      chk("R8 ch2 order", log_a[4+k], 32'h1000_0200 + 4*k);
      chk("R8 ch3 order", log_a[8+k], 32'h1000_0300 + 4*k);
    end
    rdchk("R6 link", 0, 0, mw(32'h1000_0100));
    rdchk("R6 src",  0, 1, mw(32'h1000_0104));
    rdchk("R6 id",   0, 2, mw(32'h1000_0108));
    rdchk("R6 cmd",  0, 3, mw(32'h1000_010C));
    rdchk("R5 ch2 branch", 2, 4, 32'h1000_0202);
    rdchk("R5 ch3 branch", 3, 4, 32'h1000_0300);
    chk("R5 irq count", irq_n, 1);
    chk("R5 irq ch", {29'b0, irq_ch}, 2);
    rdchk("R5 ch2 src", 2, 1, mw(32'h1000_0204));
    rdchk("R7 ch5 src", 5, 1, 0);
    rdchk("R4 ch1 link", 1, 0, 32'h1000_0500);
    rdchk("R4 ch1 src", 1, 1, 0);
    chk("R10 done", done_n, 1);
    chk("R10 busy", {31'b0, busy}, 0);

    // R3 none active: all sources cleared, no requests
    active = '0;
    reload();
    for (int c = 0; c < NCH; c++) rdchk("R3 src cleared", c, 1, 0);
    chk("R4 no req", log_n, 0);
    chk("R10 done empty", done_n, 1);

    // R9 error on ch1, ch4 continues; R10 restart ignored while busy
    wr(1, 1, 32'h1000_0E01); wr(4, 0, 32'h1000_0400); wr(4, 1, 0);
    active = 7'b0010010;
    clr_logs();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    repeat (60) @(negedge clk);
    chk("R9 berr count", berr_n, 1);
    chk("R9 berr ch", {29'b0, berr_chs}, 1);
    rdchk("R9 ch1 link kept", 1, 0, 32'h1000_0500);
    rdchk("R9 ch1 src zero", 1, 1, 0);
    rdchk("R9 ch1 branch consumed", 1, 4, 32'h1000_0E00);
    rdchk("R9 ch4 src", 4, 1, mw(32'h1000_0404));
    chk("R9 req count", log_n, 5);
    chk("R10 restart ignored", done_n, 1);

    // R7 window edges
    active = 7'b0010000;
    wr(4, 0, 32'h1000_0400);
    win_lo = 32'h1000_0400; win_hi = 32'h1000_0410;
    reload();
    chk("R7 exact fit", log_n, 4);
    wr(4, 0, 32'h1000_0400);
    win_hi = 32'h1000_040F;
    reload();
    chk("R7 one short", log_n, 0);
    rdchk("R7 src zero", 4, 1, 0);
    win_lo = 32'h1000_0000; win_hi = 32'h1000_1000;

    // R11 software branch write in the consuming cycle
    active = 7'b0000001;
    wr(0, 1, 32'h1000_0101);
    clr_logs();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    cfg_we = 1; cfg_br = 1; cfg_ch = 0; cfg_wdata = 32'h1000_0603;
    @(negedge clk); cfg_we = 0;
    repeat (30) @(negedge clk);
    rdchk("R11 write wins", 0, 4, 32'h1000_0603);
    chk("R11 old pointer used", log_a[0], 32'h1000_0100);
    chk("R11 no irq", irq_n, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule